// File: doc/BRIEF.md
# Single-Wire RGB LED Chain Transmitter

This block drives a daisy chain of single-wire addressable RGB LEDs from the system clock. A frame starts with a one-cycle start pulse and a count of LEDs. The block holds the data line low for a long reset gap. It then sends one 24-bit colour word per LED. Every bit is one pulse-width-coded cell: a one has a long high time and a short low time, and a zero has a short high time and a long low time.

All durations are given in nanoseconds as parameters. They are converted to clock cycles from a clock-frequency parameter and rounded to the nearest cycle. Colour words arrive as red/green/blue through a valid/ready handshake. The block reorders each word into the order the LEDs expect before it shifts the word out.

A word is requested in the very cycle the line must switch to it. The words therefore follow one another with no idle cycle between them. If no word is offered at that moment, the frame is closed cleanly and never sends a partial word. A busy level covers the whole frame, and a one-cycle done pulse marks its end.

Top module: `pixel_chain_tx`

## Requirements
- R1: After reset, `dout`, `busy`, `pix_ready` and `done` are all low, and `dout` stays low whenever `busy` is low.
- R2: A `start` sampled high in an idle cycle with a nonzero `led_count` raises `busy` in the next cycle. `dout` then stays low for RST_C cycles, where RST_C is the reset time rounded to the nearest cycle (50 us by default). `pix_ready` is high only in the last of those cycles.
- R3: A one bit is a cell in which `dout` is high for HI1_C cycles and then low for LO1_C cycles (900 ns and 350 ns by default, rounded to the nearest cycle).
- R4: A zero bit is a cell in which `dout` is high for HI0_C cycles and then low for LO0_C cycles (350 ns and 900 ns by default).
- R5: `pix_data` carries red in bits [23:16], green in [15:8] and blue in [7:0]. On the line, the green byte goes first, then red, then blue, and each byte is sent most significant bit first.
- R6: A word is taken in a cycle where `pix_ready` and `pix_valid` are both high. `pix_ready` rises only in the last cycle of the reset gap, or in the last low cycle of a word's final bit when more LEDs remain. The taken word's first cell begins with a rising edge in the very next cycle.
- R7: After the last low cycle of the last bit of the frame, `busy` falls, and `done` is high for exactly that one following cycle.
- R8: If `pix_valid` is low in a cycle where `pix_ready` is high, the frame ends. No further high pulse is sent, `busy` falls in the next cycle, and `done` pulses there.
- R9: `start` has no effect while `busy` is high, or when `led_count` is zero.
- R10: A `start` sampled in the same cycle as the `done` pulse is accepted, and `busy` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, sampled when idle |
| led_count | input | CNT_W | Number of LEDs in the frame |
| pix_valid | input | 1 | Colour word offered |
| pix_data | input | 24 | Colour word, red/green/blue |
| pix_ready | output | 1 | Word is taken this cycle if valid |
| dout | output | 1 | Serial line to the LED chain |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The end of one frame and the start of the next can fall in the same cycle. The bench raises `start` in the exact cycle where it sees `done` high, and requires the reset gap of the new frame to begin at once (R10).

A word fetch also coincides with the final low cycle of the previous word's last bit. The bench therefore compares the line level cycle by cycle against its reference model across word boundaries. It also withholds a word at that point to check that the frame closes cleanly (R8).

// File: rtl/pxl_pkg.sv
package pxl_pkg;

   localparam int unsigned WORD_W = 24;
   localparam int unsigned CHAN_W = 8;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_RESET = 2'd1,
      FR_SEND  = 2'd2
   } fr_state_t;

   // nanoseconds to clock cycles, rounded to the nearest cycle
   function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
      longint unsigned prod;
      prod = hz * ns + 64'd500_000_000;
      return int'(prod / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/pxl_order.sv
module pxl_order #(
   parameter int unsigned ORDER = 0   // 0: green-red-blue, 1: red-green-blue
) (
   input  logic [pxl_pkg::WORD_W-1:0] rgb_in,
   output logic [pxl_pkg::WORD_W-1:0] line_word
);
   localparam int unsigned C = pxl_pkg::CHAN_W;

   generate
      if (ORDER == 0) begin : g_grb
         assign line_word = {rgb_in[2*C-1:C], rgb_in[3*C-1:2*C], rgb_in[C-1:0]};
      end else if (ORDER == 1) begin : g_rgb
         assign line_word = rgb_in;
      end else begin : g_bad
         $error("pxl_order: unsupported ORDER");
         assign line_word = rgb_in;
      end
   endgenerate
endmodule

// File: rtl/pxl_cell.sv
module pxl_cell #(
   parameter int unsigned HI1 = 90,
   parameter int unsigned LO1 = 35,
   parameter int unsigned HI0 = 35,
   parameter int unsigned LO0 = 90
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,     // start a cell with bit_in in the next cycle
   input  logic bit_in,
   output logic line,
   output logic last      // final low cycle of the running cell
);
   localparam int unsigned LEN1   = HI1 + LO1;
   localparam int unsigned LEN0   = HI0 + LO0;
   localparam int unsigned MAXLEN = (LEN1 > LEN0) ? LEN1 : LEN0;
   localparam int unsigned CW     = $clog2(MAXLEN + 1);
   localparam logic [CW-1:0] HI1_C = CW'(HI1);
   localparam logic [CW-1:0] HI0_C = CW'(HI0);
   localparam logic [CW-1:0] END1  = CW'(LEN1 - 1);
   localparam logic [CW-1:0] END0  = CW'(LEN0 - 1);

   generate
      if (HI1 < 1 || LO1 < 1 || HI0 < 1 || LO0 < 1) begin : g_zero_phase
         $error("pxl_cell: every phase needs at least one cycle");
      end
      if (HI0 >= HI1) begin : g_ambiguous
         $error("pxl_cell: a one must stay high longer than a zero");
      end
   endgenerate

   logic          active;
   logic          val;
   logic [CW-1:0] cnt;
   logic [CW-1:0] hi_len;
   logic [CW-1:0] end_cnt;

   assign hi_len  = val ? HI1_C : HI0_C;
   assign end_cnt = val ? END1 : END0;
   assign line    = active && (cnt < hi_len);
   assign last    = active && (cnt == end_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         val    <= 1'b0;
         cnt    <= '0;
      end else if (load) begin
         active <= 1'b1;
         val    <= bit_in;
         cnt    <= '0;
      end else if (last) begin
         active <= 1'b0;
      end else if (active) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R3 R4: every cell opens with a rising edge right after a load
   a_r3_rise_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line) |-> $past(load));
   // R4: a cell never ends while the line is still high
   a_r4_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> !line);
endmodule

// File: rtl/pxl_frame.sv
module pxl_frame #(
   parameter int unsigned RST_CYC = 5000,
   parameter int unsigned CNT_W   = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [CNT_W-1:0]            led_count,
   input  logic                        pix_valid,
   input  logic [pxl_pkg::WORD_W-1:0]  word_in,
   input  logic                        cell_last,
   output logic                        pix_ready,
   output logic                        cell_load,
   output logic                        cell_bit,
   output logic                        busy,
   output logic                        done
);
   import pxl_pkg::*;

   localparam int unsigned RW = $clog2(RST_CYC + 1);
   localparam int unsigned BW = $clog2(WORD_W);
   localparam logic [RW-1:0] RST_END  = RW'(RST_CYC - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

   generate
      if (RST_CYC < 2) begin : g_short_reset
         $error("pxl_frame: reset gap needs at least two cycles");
      end
      if (CNT_W < 1) begin : g_no_count
         $error("pxl_frame: CNT_W must be positive");
      end
   endgenerate

   fr_state_t          state;
   logic [RW-1:0]      rtmr;
   logic [CNT_W-1:0]   left;
   logic [WORD_W-1:0]  shreg;
   logic [BW-1:0]      bidx;

   logic rst_end, word_end, mid_next, take, finish;

   assign rst_end   = (state == FR_RESET) && (rtmr == RST_END);
   assign word_end  = (state == FR_SEND) && cell_last && (bidx == LAST_BIT);
   assign mid_next  = (state == FR_SEND) && cell_last && (bidx != LAST_BIT);
   assign pix_ready = rst_end || (word_end && (left != '0));
   assign take      = pix_ready && pix_valid;
   assign cell_load = take || mid_next;
   assign cell_bit  = take ? word_in[WORD_W-1] : shreg[WORD_W-1];
   assign finish    = (rst_end && !pix_valid) || (word_end && !take);
   assign busy      = (state != FR_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FR_IDLE;
         rtmr  <= '0;
         left  <= '0;
         shreg <= '0;
         bidx  <= '0;
         done  <= 1'b0;
      end else begin
         done <= finish;
         case (state)
            FR_IDLE: begin
               if (start && (led_count != '0)) begin
                  state <= FR_RESET;
                  rtmr  <= '0;
                  left  <= led_count;
               end
            end
            FR_RESET: begin
               if (!rst_end) rtmr <= rtmr + 1'b1;
            end
            default: ;
         endcase
         if (take) begin
            shreg <= word_in << 1;
            bidx  <= '0;
            left  <= left - 1'b1;
            state <= FR_SEND;
         end else if (mid_next) begin
            shreg <= shreg << 1;
            bidx  <= bidx + 1'b1;
         end
         if (finish) state <= FR_IDLE;
      end
   end

   // R7: done is a single-cycle pulse
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: done appears in the first idle cycle after a frame
   a_r7_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R6: words are only requested inside a frame
   a_r6_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |-> busy);
   // R9: the LED count is not disturbed during the reset gap
   a_r9_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_RESET && !rst_end) |=> $stable(left));
endmodule

// File: rtl/pixel_chain_tx.sv
module pixel_chain_tx #(
   parameter longint unsigned CLK_HZ = 100_000_000,
   parameter int unsigned     HI1_NS = 900,
   parameter int unsigned     LO1_NS = 350,
   parameter int unsigned     HI0_NS = 350,
   parameter int unsigned     LO0_NS = 900,
   parameter int unsigned     RST_NS = 50_000,
   parameter int unsigned     CNT_W  = 10,
   parameter int unsigned     ORDER  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] led_count,
   input  logic             pix_valid,
   input  logic [23:0]      pix_data,
   output logic             pix_ready,
   output logic             dout,
   output logic             busy,
   output logic             done
);
   import pxl_pkg::*;

   localparam int unsigned HI1_C = ns_to_cycles(CLK_HZ, HI1_NS);
   localparam int unsigned LO1_C = ns_to_cycles(CLK_HZ, LO1_NS);
   localparam int unsigned HI0_C = ns_to_cycles(CLK_HZ, HI0_NS);
   localparam int unsigned LO0_C = ns_to_cycles(CLK_HZ, LO0_NS);
   localparam int unsigned RST_C = ns_to_cycles(CLK_HZ, RST_NS);

   logic [WORD_W-1:0] line_word;
   logic              cell_load, cell_bit, cell_last;

   pxl_order #(.ORDER(ORDER)) u_order (
      .rgb_in   (pix_data),
      .line_word(line_word)
   );

   pxl_frame #(.RST_CYC(RST_C), .CNT_W(CNT_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .led_count(led_count),
      .pix_valid(pix_valid),
      .word_in  (line_word),
      .cell_last(cell_last),
      .pix_ready(pix_ready),
      .cell_load(cell_load),
      .cell_bit (cell_bit),
      .busy     (busy),
      .done     (done)
   );

   pxl_cell #(.HI1(HI1_C), .LO1(LO1_C), .HI0(HI0_C), .LO0(LO0_C)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cell_load),
      .bit_in(cell_bit),
      .line  (dout),
      .last  (cell_last)
   );

   // R1: the line is low outside a frame
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dout);
   // R8: a frame is closed with the line low
   a_r8_end_low: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dout);
endmodule

// File: tb/pixel_chain_tx_test.sv
module pixel_chain_tx_test;
   // timing at CLK_HZ = 20 MHz, rounded to the nearest cycle
   localparam int HI1 = 18;
   localparam int LO1 = 7;
   localparam int HI0 = 7;
   localparam int LO0 = 18;
   localparam int RST = 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] led_count = '0;
   logic       pix_valid;
   logic [23:0] pix_data;
   logic       pix_ready, dout, busy, done;

   int vectors = 0;
   int fails = 0;
   int cycles = 0;
   int rises = 0;
   logic prev_dout = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   pixel_chain_tx #(.CLK_HZ(20_000_000), .CNT_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .led_count(led_count),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
      .dout(dout), .busy(busy), .done(done)
   );

   // ---------------- word feeder ----------------
   logic [23:0] feed[$];
   bit took = 0;
   assign pix_valid = (feed.size() > 0);
   assign pix_data  = (feed.size() > 0) ? feed[0] : 24'h0;

   always @(negedge clk) begin
      if (took) void'(feed.pop_front());
      took = pix_ready && (feed.size() > 0);
   end

   // ---------------- reference model ----------------
   int m_mode = 0;   // 0 idle, 1 reset gap, 2 sending
   int m_rc = 0, m_left = 0, m_cc = 0;
   bit m_done = 0;
   bit m_bits[$];

   function automatic int cell_len(bit b);
      return b ? HI1 + LO1 : HI0 + LO0;
   endfunction

   task automatic m_load(input logic [23:0] rgb);
      logic [23:0] w;
      w = {rgb[15:8], rgb[23:16], rgb[7:0]};   // R5 green, red, blue
      for (int i = 23; i >= 0; i--) m_bits.push_back(w[i]);
      m_left--;
      m_mode = 2;
      m_cc = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_done = 0; m_bits.delete();
      end else begin
         bit fin;
         fin = 0;
         case (m_mode)
            0: if (start && led_count != 0) begin
                  m_mode = 1; m_rc = 0; m_left = led_count;
               end
            1: if (m_rc == RST - 1) begin
                  if (pix_valid) m_load(pix_data); else fin = 1;
               end else m_rc++;
            default: if (m_cc == cell_len(m_bits[0]) - 1) begin
                  void'(m_bits.pop_front());
                  m_cc = 0;
                  if (m_bits.size() == 0) begin
                     if (m_left > 0 && pix_valid) m_load(pix_data); else fin = 1;
                  end
               end else m_cc++;
         endcase
         m_done = fin;
         if (fin) m_mode = 0;
      end
   end

   // ---------------- per-cycle comparison ----------------
   task automatic check(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         logic e_dout, e_ready;
         e_dout = (m_mode == 2) && (m_cc < (m_bits[0] ? HI1 : HI0));
         e_ready = (m_mode == 1 && m_rc == RST - 1) ||
                   (m_mode == 2 && m_bits.size() == 1 &&
                    m_cc == cell_len(m_bits[0]) - 1 && m_left > 0);
         check("R3 R4 R5 R6 dout", dout, e_dout);
         check("R2 R6 R8 pix_ready", pix_ready, e_ready);
         check("R2 R7 R9 R10 busy", busy, m_mode != 0);
         check("R7 R8 done", done, m_done);
         if (dout && !prev_dout) rises++;
         prev_dout = dout;
      end
   end

   // ---------------- watchdog ----------------
   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150_000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected at most 150000", cycles);
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   task automatic pulse_start(input int n);
      led_count = 4'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 dout", dout, 1'b0);
      check("R1 busy", busy, 1'b0);
      check("R1 pix_ready", pix_ready, 1'b0);
      check("R1 done", done, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // two LEDs, mixed ones and zeros, back to back (R3 R4 R5 R6)
      feed.push_back(24'hFF0081);
      feed.push_back(24'h12C3A5);
      rises = 0;
      pulse_start(2);
      check("R2 busy after start", busy, 1'b1);
      repeat (100) @(negedge clk);
      pulse_start(5);   // R9 ignored while busy
      wait_done();
      check("R6 two words sent", (rises == 48), 1'b1);

      // R10 start in the done cycle
      feed.push_back(24'h00FF00);
      rises = 0;
      pulse_start(1);
      check("R10 busy right after done", busy, 1'b1);
      wait_done();
      check("R7 one word sent", (rises == 24), 1'b1);
      repeat (3) @(negedge clk);

      // R9 zero count ignored
      pulse_start(0);
      repeat (2) @(negedge clk);
      check("R9 zero count busy", busy, 1'b0);

      // R8 words run out after the first of three
      feed.push_back(24'h5A5A5A);
      rises = 0;
      pulse_start(3);
      wait_done();
      check("R8 partial frame stops on word boundary", (rises == 24), 1'b1);
      repeat (3) @(negedge clk);

      // R8 no word at the end of the reset gap
      rises = 0;
      pulse_start(1);
      wait_done();
      check("R8 empty frame sends nothing", (rises == 0), 1'b1);
      repeat (5) @(negedge clk);
      check("R1 idle after frames", busy, 1'b0);
      finish_run();
   end
endmodule